// File: doc/BRIEF.md
# Link Request Serial Decoder

This block sits on the physical-layer side of a serial link and listens to a single request wire driven by the link controller. The wire idles low. A sampled 1 opens a frame. The block collects the bits that follow, one per clock. It reads the three-bit type field early in the frame and uses it to decide how long the frame will be. When the frame ends, it produces a decoded request. Bus requests may end in one of two places: a request whose last speed bit is 0 may leave out its stop bit.

Each completed frame gives exactly one single-cycle pulse. The pulse is a valid pulse when the frame decodes correctly. It is a framing-error pulse when a required stop position holds a 1. It is a reserved-code pulse when the frame carries the unused type. Decoded fields sit on registered outputs and change only when a valid pulse updates them. Arbitration, register storage and the status return path all live in other blocks.

Top module: `lreq_decoder`

## Requirements
- R1: While no frame is open, a 0 on the request line produces no event; a sampled 1 opens a frame, and that 1 is stream bit 0.
- R2: Stream bits 1..3 form the type, with bit 1 as the most significant bit. The codes are: 0 immediate, 1 isochronous, 2 priority, 3 fair, 4 register read, 5 register write, 6 acceleration control, 7 reserved. The code is presented on `out_kind`.
- R3: For a bus request (types 0 to 3), bits 4..6 give the speed, with bit 4 as the most significant bit. If bit 6 is 0, the frame ends after bit 6, and `out_valid` is high in the cycle after bit 6 is sampled. A 0 that follows is treated as idle line.
- R4: A bus request whose bit 6 is 1 takes a stop bit at position 7. `out_valid` rises in the cycle after the stop bit is sampled.
- R5: A register read is 9 bits long. Bits 4..7 are the register address, most significant bit first, and bit 8 is the stop bit.
- R6: A register write is 17 bits long. Bits 4..7 are the address and bits 8..15 are the data, both most significant bit first. Bit 16 is the stop bit.
- R7: An acceleration-control request is 6 bits long. Bit 4 is the enable and bit 5 is the stop bit.
- R8: A 1 in a required stop position gives a one-cycle `out_frame_err` pulse instead of `out_valid`, and every output field keeps its earlier value.
- R9: A reserved type code ends after 6 bits (bit 5 is the stop position). It gives a one-cycle `out_rsvd_err` pulse and no `out_valid`, and the fields are unchanged. If that stop position holds a 1, `out_frame_err` also pulses.
- R10: `out_valid` lasts one cycle. A field loads only on a valid pulse whose type carries that field: speed for bus requests, address for reads and writes, data for writes, enable for acceleration control. Type loads on every valid pulse. At all other times every field holds its value.
- R11: A new start bit may come in the cycle right after the last bit of a frame, and it is decoded with no gap.
- R12: A synchronous active-high reset, asserted even partway through a frame, returns the block to idle. It clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the request line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_line | input | 1 | Serial request line from the link controller |
| out_valid | output | 1 | One-cycle pulse: a correct request was decoded |
| out_kind | output | 3 | Request type code |
| out_speed | output | 3 | Speed of the last bus request |
| out_addr | output | 4 | Register address of the last read or write |
| out_wdata | output | 8 | Data of the last register write |
| out_accel_en | output | 1 | Enable bit of the last acceleration-control request |
| out_frame_err | output | 1 | One-cycle pulse: stop position held a 1 |
| out_rsvd_err | output | 1 | One-cycle pulse: reserved type frame ended |

## Verification
A bit counter that is off by one shows at the ports within one frame. The pulse comes a cycle early or late, the fields pick up neighbouring bits, or a data bit is read as the stop position and raises a false framing error. A wrong decision about the length of a short bus request shows on the next frame: the block either stays in the frame and takes the next start bit as a stop bit, or it ends early. A wrong field-load rule shows as a field that changes on an error frame or on a valid pulse of another type. The sweeps cover every type, speed and address, and the bench checks every pulse and the cycle after it.

// File: rtl/lreq_pkg.sv
package lreq_pkg;

    localparam int KIND_W    = 3;
    localparam int SPEED_W   = 3;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;

    // stream positions derived from the field widths
    localparam int KIND_LO   = 1;
    localparam int BODY_IDX  = KIND_LO + KIND_W;          // first payload bit
    localparam int BUS_STOP  = BODY_IDX + SPEED_W;        // optional stop of bus request
    localparam int BUS_LAST  = BUS_STOP - 1;              // last speed bit
    localparam int RD_STOP   = BODY_IDX + ADDR_W;
    localparam int DATA_IDX  = RD_STOP;                   // write data follows address
    localparam int WR_STOP   = DATA_IDX + DATA_W;
    localparam int ACC_STOP  = BODY_IDX + 1;
    localparam int RSV_STOP  = ACC_STOP;
    localparam int FRAME_MAX = WR_STOP + 1;
    localparam int IDX_W     = $clog2(FRAME_MAX);

    typedef logic [IDX_W-1:0] idx_t;
    // captured payload: stream bit i lives at index i
    typedef logic [WR_STOP-1:KIND_LO] frame_t;

    typedef enum logic [KIND_W-1:0] {
        K_IMM   = 3'd0,
        K_ISO   = 3'd1,
        K_PRI   = 3'd2,
        K_FAIR  = 3'd3,
        K_RDREG = 3'd4,
        K_WRREG = 3'd5,
        K_ACCEL = 3'd6,
        K_RSVD  = 3'd7
    } req_kind_e;

    typedef struct packed {
        req_kind_e           kind;
        logic [SPEED_W-1:0]  speed;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                accel_en;
    } req_fields_t;

    function automatic logic is_bus(req_kind_e k);
        return k inside {K_IMM, K_ISO, K_PRI, K_FAIR};
    endfunction

    function automatic logic has_addr(req_kind_e k);
        return k inside {K_RDREG, K_WRREG};
    endfunction

    function automatic logic has_data(req_kind_e k);
        return k == K_WRREG;
    endfunction

    function automatic logic has_enable(req_kind_e k);
        return k == K_ACCEL;
    endfunction

    // position of the mandatory stop bit for each type
    function automatic idx_t stop_index(req_kind_e k);
        case (k)
            K_IMM, K_ISO, K_PRI, K_FAIR: return idx_t'(BUS_STOP);
            K_RDREG:                     return idx_t'(RD_STOP);
            K_WRREG:                     return idx_t'(WR_STOP);
            K_ACCEL:                     return idx_t'(ACC_STOP);
            default:                     return idx_t'(RSV_STOP);
        endcase
    endfunction

endpackage

// File: rtl/lreq_frame_track.sv
module lreq_frame_track
    import lreq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line,
    input  req_kind_e kind,
    output logic      busy,
    output idx_t      idx,
    output logic      fin,
    output logic      ev_ok,
    output logic      ev_ferr,
    output logic      ev_rsvd
);

    logic at_stop;
    logic short_end;

    // type is known only once the payload region is reached
    assign at_stop   = busy && (idx >= idx_t'(BODY_IDX)) && (idx == stop_index(kind));
    assign short_end = busy && is_bus(kind) && (idx == idx_t'(BUS_LAST)) && !line;
    assign fin       = at_stop || short_end;

    assign ev_ferr = at_stop && line;
    assign ev_rsvd = at_stop && (kind == K_RSVD);
    assign ev_ok   = short_end || (at_stop && !line && (kind != K_RSVD));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (line) begin
                busy <= 1'b1;
                idx  <= idx_t'(KIND_LO);
            end
        end else if (fin) begin
            busy <= 1'b0;
            idx  <= '0;
        end else begin
            idx  <= idx + idx_t'(1);
        end
    end

    // R1: a low line leaves an idle tracker idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !line) |=> !busy);

    // R6: no frame runs past the longest stop position
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == idx_t'(WR_STOP)) |-> fin);

endmodule

// File: rtl/lreq_bit_collect.sv
module lreq_bit_collect
    import lreq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line,
    input  logic      busy,
    input  idx_t      idx,
    output frame_t    frame_now,
    output req_kind_e kind
);

    frame_t              frame_q;
    logic [KIND_W-1:0]   kind_bits;

    for (genvar i = KIND_LO; i < WR_STOP; i++) begin : g_cell
        logic hit;
        assign hit = busy && (idx == idx_t'(i));
        always_ff @(posedge clk) begin
            if (rst)      frame_q[i] <= 1'b0;
            else if (hit) frame_q[i] <= line;
        end
        // the bit on the line this cycle joins the stored ones
        assign frame_now[i] = hit ? line : frame_q[i];
    end

    for (genvar j = 0; j < KIND_W; j++) begin : g_kind
        assign kind_bits[KIND_W-1-j] = frame_q[KIND_LO+j];
    end

    assign kind = req_kind_e'(kind_bits);

    // R2: the type field stays frozen once the payload is under way
    p_kind_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && idx > idx_t'(BODY_IDX)) |-> $stable(kind));

endmodule

// File: rtl/lreq_field_dec.sv
module lreq_field_dec
    import lreq_pkg::*;
(
    input  frame_t      frame_now,
    output req_fields_t fields
);

    logic [KIND_W-1:0]  k_bits;
    logic [SPEED_W-1:0] s_bits;
    logic [ADDR_W-1:0]  a_bits;
    logic [DATA_W-1:0]  d_bits;

    for (genvar j = 0; j < KIND_W; j++) begin : g_k
        assign k_bits[KIND_W-1-j] = frame_now[KIND_LO+j];
    end
    for (genvar j = 0; j < SPEED_W; j++) begin : g_s
        assign s_bits[SPEED_W-1-j] = frame_now[BODY_IDX+j];
    end
    for (genvar j = 0; j < ADDR_W; j++) begin : g_a
        assign a_bits[ADDR_W-1-j] = frame_now[BODY_IDX+j];
    end
    for (genvar j = 0; j < DATA_W; j++) begin : g_d
        assign d_bits[DATA_W-1-j] = frame_now[DATA_IDX+j];
    end

    always_comb begin
        fields.kind     = req_kind_e'(k_bits);
        fields.speed    = s_bits;
        fields.addr     = a_bits;
        fields.wdata    = d_bits;
        fields.accel_en = frame_now[BODY_IDX];
    end

endmodule

// File: rtl/lreq_out_stage.sv
module lreq_out_stage
    import lreq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_ok,
    input  logic        ev_ferr,
    input  logic        ev_rsvd,
    input  req_fields_t fields_now,
    output logic        valid,
    output logic        ferr,
    output logic        rsvd,
    output req_fields_t fields_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            ferr     <= 1'b0;
            rsvd     <= 1'b0;
            fields_q <= '0;
        end else begin
            valid <= ev_ok;
            ferr  <= ev_ferr;
            rsvd  <= ev_rsvd;
            if (ev_ok) begin
                fields_q.kind <= fields_now.kind;
                if (is_bus(fields_now.kind))
                    fields_q.speed <= fields_now.speed;
                if (has_addr(fields_now.kind))
                    fields_q.addr <= fields_now.addr;
                if (has_data(fields_now.kind))
                    fields_q.wdata <= fields_now.wdata;
                if (has_enable(fields_now.kind))
                    fields_q.accel_en <= fields_now.accel_en;
            end
        end
    end

    // R8: a frame reports either success or a framing error, never both
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({valid, ferr}));

    // R9: a reserved frame never yields a valid request
    p_rsvd_not_valid_r9: assert property (@(posedge clk) disable iff (rst)
        rsvd |-> !valid);

    // R10: fields move only together with the valid pulse
    p_fields_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(fields_q));

    // R10: the valid pulse lasts a single cycle
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/lreq_decoder.sv
module lreq_decoder
    import lreq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_line,
    output logic               out_valid,
    output logic [KIND_W-1:0]  out_kind,
    output logic [SPEED_W-1:0] out_speed,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [DATA_W-1:0]  out_wdata,
    output logic               out_accel_en,
    output logic               out_frame_err,
    output logic               out_rsvd_err
);

    logic        busy;
    idx_t        idx;
    logic        fin;
    logic        ev_ok;
    logic        ev_ferr;
    logic        ev_rsvd;
    req_kind_e   kind;
    frame_t      frame_now;
    req_fields_t fields_now;
    req_fields_t fields_q;

    lreq_frame_track u_track (
        .clk     (clk),
        .rst     (rst),
        .line    (req_line),
        .kind    (kind),
        .busy    (busy),
        .idx     (idx),
        .fin     (fin),
        .ev_ok   (ev_ok),
        .ev_ferr (ev_ferr),
        .ev_rsvd (ev_rsvd)
    );

    lreq_bit_collect u_collect (
        .clk       (clk),
        .rst       (rst),
        .line      (req_line),
        .busy      (busy),
        .idx       (idx),
        .frame_now (frame_now),
        .kind      (kind)
    );

    lreq_field_dec u_dec (
        .frame_now (frame_now),
        .fields    (fields_now)
    );

    lreq_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .ev_ok      (ev_ok),
        .ev_ferr    (ev_ferr),
        .ev_rsvd    (ev_rsvd),
        .fields_now (fields_now),
        .valid      (out_valid),
        .ferr       (out_frame_err),
        .rsvd       (out_rsvd_err),
        .fields_q   (fields_q)
    );

    assign out_kind     = fields_q.kind;
    assign out_speed    = fields_q.speed;
    assign out_addr     = fields_q.addr;
    assign out_wdata    = fields_q.wdata;
    assign out_accel_en = fields_q.accel_en;

    // R11: a frame that ends always leaves the tracker free for the next cycle
    p_fin_frees_r11: assert property (@(posedge clk) disable iff (rst)
        (fin && !req_line) |=> !busy);

endmodule

// File: tb/tb_lreq_decoder.sv
module tb_lreq_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_line = 1'b0;
    logic       out_valid;
    logic [2:0] out_kind;
    logic [2:0] out_speed;
    logic [3:0] out_addr;
    logic [7:0] out_wdata;
    logic       out_accel_en;
    logic       out_frame_err;
    logic       out_rsvd_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // expected held fields
    logic [2:0] m_kind  = '0;
    logic [2:0] m_speed = '0;
    logic [3:0] m_addr  = '0;
    logic [7:0] m_data  = '0;
    logic       m_acc   = 1'b0;

    lreq_decoder dut (
        .clk           (clk),
        .rst           (rst),
        .req_line      (req_line),
        .out_valid     (out_valid),
        .out_kind      (out_kind),
        .out_speed     (out_speed),
        .out_addr      (out_addr),
        .out_wdata     (out_wdata),
        .out_accel_en  (out_accel_en),
        .out_frame_err (out_frame_err),
        .out_rsvd_err  (out_rsvd_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic observe(input string req, input logic ev_v, input logic ev_f, input logic ev_r);
        logic [21:0] act;
        logic [21:0] exp;
        act = {out_valid, out_frame_err, out_rsvd_err, out_kind, out_speed, out_addr, out_wdata, out_accel_en};
        exp = {ev_v, ev_f, ev_r, m_kind, m_speed, m_addr, m_data, m_acc};
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        req_line = b;
        @(negedge clk);
    endtask

    task automatic send_val(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic idle_check(input string req);
        send_bit(1'b0);
        observe(req, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_head(input logic [2:0] k);
        send_bit(1'b1);
        send_val({13'd0, k}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        observe("R12 reset state", 1'b0, 1'b0, 1'b0);

        // R1: a quiet line raises nothing
        for (int c = 0; c < 8; c++) idle_check("R1 idle line");

        // R2 R3 R4: every bus type at every speed
        for (int k = 0; k < 4; k++) begin
            for (int sp = 0; sp < 8; sp++) begin
                send_head(3'(k));
                send_val(16'(sp), 3);
                if (sp[0]) send_bit(1'b0);
                m_kind  = 3'(k);
                m_speed = 3'(sp);
                observe(sp[0] ? "R4 bus with stop" : "R3 short bus", 1'b1, 1'b0, 1'b0);
                idle_check("R10 pulse ends, following zero idle");
            end
        end

        // R5: every read address
        for (int a = 0; a < 16; a++) begin
            send_head(3'd4);
            send_val(16'(a), 4);
            send_bit(1'b0);
            m_kind = 3'd4;
            m_addr = 4'(a);
            observe("R5 read", 1'b1, 1'b0, 1'b0);
            idle_check("R10 read hold");
        end

        // R6: writes over every address with two data patterns
        for (int a = 0; a < 16; a++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] d;
                d = 8'((a * 37 + 11) & 8'hFF);
                if (p == 1) d = ~d;
                send_head(3'd5);
                send_val(16'(a), 4);
                send_val({8'd0, d}, 8);
                send_bit(1'b0);
                m_kind = 3'd5;
                m_addr = 4'(a);
                m_data = d;
                observe("R6 write", 1'b1, 1'b0, 1'b0);
                idle_check("R10 write hold");
            end
        end

        // R7: acceleration enable both ways
        for (int e = 0; e < 2; e++) begin
            send_head(3'd6);
            send_bit(e[0]);
            send_bit(1'b0);
            m_kind = 3'd6;
            m_acc  = e[0];
            observe("R7 accel", 1'b1, 1'b0, 1'b0);
            idle_check("R10 accel hold");
        end

        // R8: bad stop bits on each frame kind, fields must hold
        send_head(3'd1); send_val(16'd5, 3); send_bit(1'b1);
        observe("R8 bus stop error", 1'b0, 1'b1, 1'b0);
        idle_check("R8 after bus error");
        send_head(3'd4); send_val(16'd3, 4); send_bit(1'b1);
        observe("R8 read stop error", 1'b0, 1'b1, 1'b0);
        idle_check("R8 after read error");
        send_head(3'd5); send_val(16'd9, 4); send_val(16'h3C, 8); send_bit(1'b1);
        observe("R8 write stop error", 1'b0, 1'b1, 1'b0);
        idle_check("R8 after write error");
        send_head(3'd6); send_bit(~m_acc); send_bit(1'b1);
        observe("R8 accel stop error", 1'b0, 1'b1, 1'b0);
        idle_check("R8 after accel error");

        // R9: reserved code, good and bad stop
        send_head(3'd7); send_bit(1'b1); send_bit(1'b0);
        observe("R9 reserved", 1'b0, 1'b0, 1'b1);
        idle_check("R9 after reserved");
        send_head(3'd7); send_bit(1'b0); send_bit(1'b1);
        observe("R9 reserved bad stop", 1'b0, 1'b1, 1'b1);
        idle_check("R9 after reserved bad stop");

        // R11: short bus then a read with no gap, then write stop into accel
        send_head(3'd2); send_val(16'd6, 3);
        m_kind = 3'd2; m_speed = 3'd6;
        observe("R11 short bus before chain", 1'b1, 1'b0, 1'b0);
        send_head(3'd4); send_val(16'd9, 4); send_bit(1'b0);
        m_kind = 3'd4; m_addr = 4'd9;
        observe("R11 chained read", 1'b1, 1'b0, 1'b0);
        send_head(3'd6); send_bit(1'b1); send_bit(1'b0);
        m_kind = 3'd6; m_acc = 1'b1;
        observe("R11 chained accel", 1'b1, 1'b0, 1'b0);
        idle_check("R11 after chain");

        // R12: reset in the middle of a frame
        send_head(3'd5); send_val(16'd2, 2);
        req_line = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_kind = '0; m_speed = '0; m_addr = '0; m_data = '0; m_acc = 1'b0;
        @(negedge clk);
        observe("R12 mid-frame reset", 1'b0, 1'b0, 1'b0);
        send_head(3'd3); send_val(16'd7, 3); send_bit(1'b0);
        m_kind = 3'd3; m_speed = 3'd7;
        observe("R12 decode after reset", 1'b1, 1'b0, 1'b0);
        idle_check("R12 idle after reset frame");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule